// File: doc/BRIEF.md
# Reservation Station Pool with Wakeup and Age-Ordered Select

This block holds instructions that have been issued but not yet executed, for one class of unpipelined execution units. Examples are a pool of integer units, a pool of floating-point adders, or a mixed pool in which one set of stations feeds both multipliers and dividers. Each station holds an opcode, a destination reorder-buffer tag, and two source operands. Each operand is held either as a value or as the tag of the instruction that will produce it. The stations watch a single result broadcast bus. When a broadcast carries the tag a station is waiting for, the station takes the value.

Each cycle, a free unit is granted the oldest station that has both operands and that targets the unit's kind. Age follows issue order, not station index. The granted unit runs for its configured latency and then holds its result until that result is written on the broadcast bus. The write-result broadcast carries the instruction's destination tag, and it releases both the station and the unit. Each can be reused from the following cycle.

The pool has two unit kinds, A and B, with their own counts and latencies. Each issued instruction names the kind it needs. The result value itself is computed outside the block. This block models the units only as fixed-latency timers that carry the operands.

Top module: `rs_pool`

## Requirements
- R1: After reset, `iss_ready` is 1 and every bit of `ex_busy` and `ex_done` is 0.
- R2: An instruction is accepted only in a cycle where `iss_valid` and `iss_ready` are both 1. `iss_ready` is 0 exactly when all `NUM_RS` stations are occupied. An `iss_valid` pulse while `iss_ready` is 0 leaves no trace.
- R3: A station waiting on tag T sees a broadcast of T in cycle t. If a matching unit is free, that unit shows `ex_busy`=1 in cycle t+1, and its `ex_a`/`ex_b` hold the broadcast value.
- R4: An operand whose tag is broadcast in the same cycle the instruction is issued is stored as the broadcast value. The instruction can then be granted in the next cycle, so its unit is busy two cycles after issue.
- R5: When several stations are eligible for the same free unit, the station issued earliest is granted, whatever its station index. A unit is granted at most one station per cycle.
- R6: A unit first shows `ex_busy`=1 in cycle s. With a latency of L for its kind, `ex_done` is 0 in cycles s to s+L-2 and becomes 1 in cycle s+L-1.
- R7: A unit stays busy, with `ex_done`=1, until a broadcast carries its `ex_tag`. Broadcasts of other tags leave it busy. In the cycle after its write-result, `ex_busy` is 0, and a waiting eligible station can start on it in the cycle after that.
- R8: A station is released by the write-result broadcast of its destination tag and can be allocated from the next cycle. When the pool was full, `iss_ready` returns to 1 in that next cycle.
- R9: `iss_kind`=0 routes an instruction only to units 0 to `NUM_A`-1 (kind A). `iss_kind`=1 routes it only to units `NUM_A` to `NUM_A+NUM_B`-1 (kind B).
- R10: A station with an operand still waiting on a tag is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free this cycle |
| iss_kind | input | 1 | Unit kind required: 0 = A, 1 = B |
| iss_op | input | OPW | Opcode carried to the unit |
| iss_dst | input | TW | Destination reorder-buffer tag |
| iss_a_rdy | input | 1 | Operand A is a value (1) or a tag (0) |
| iss_a_tag | input | TW | Producer tag of operand A |
| iss_a_val | input | DW | Value of operand A |
| iss_b_rdy | input | 1 | Operand B is a value (1) or a tag (0) |
| iss_b_tag | input | TW | Producer tag of operand B |
| iss_b_val | input | DW | Value of operand B |
| cdb_valid | input | 1 | Result broadcast valid (write-result) |
| cdb_tag | input | TW | Tag of the broadcast result |
| cdb_val | input | DW | Broadcast result value |
| ex_busy | output | NUM_A+NUM_B | Unit occupied, one bit per unit |
| ex_done | output | NUM_A+NUM_B | Unit latency elapsed, result awaiting write-result |
| ex_tag | output | (NUM_A+NUM_B)*TW | Destination tag per unit, unit u at bits u*TW upward |
| ex_op | output | (NUM_A+NUM_B)*OPW | Opcode per unit |
| ex_a | output | (NUM_A+NUM_B)*DW | Operand A per unit |
| ex_b | output | (NUM_A+NUM_B)*DW | Operand B per unit |

## Verification
The bench builds the pool with four stations, one kind-A unit of latency 2 and one kind-B unit of latency 3, with 16-bit data and 4-bit tags. With a single unit per kind, a backlog of ready stations is easy to create. This lets the bench show age order beating index order: a younger instruction in a lower-numbered station is passed over for an older one. Four stations are few enough to fill the pool and test rejection and refill. The two latencies let the bench check done timing for both kinds and confirm that each kind stays on its own unit.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

  typedef enum logic {
    KIND_A = 1'b0,
    KIND_B = 1'b1
  } ukind_e;

  // Units 0..num_a-1 are kind A, the rest kind B.
  function automatic ukind_e kind_of_unit(input int u, input int num_a);
    return (u < num_a) ? KIND_A : KIND_B;
  endfunction

endpackage

// File: rtl/rs_slots.sv
module rs_slots #(
  parameter int NRS = 4,
  parameter int DW  = 32,
  parameter int TW  = 4,
  parameter int OPW = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     iss_valid,
  output logic                     iss_ready,
  input  logic                     iss_kind,
  input  logic [OPW-1:0]           iss_op,
  input  logic [TW-1:0]            iss_dst,
  input  logic                     iss_a_rdy,
  input  logic [TW-1:0]            iss_a_tag,
  input  logic [DW-1:0]            iss_a_val,
  input  logic                     iss_b_rdy,
  input  logic [TW-1:0]            iss_b_tag,
  input  logic [DW-1:0]            iss_b_val,
  input  logic                     cdb_valid,
  input  logic [TW-1:0]            cdb_tag,
  input  logic [DW-1:0]            cdb_val,
  input  logic [NRS-1:0]           taken,
  output logic [NRS-1:0]           cand,
  output logic [NRS-1:0]           skind,
  output logic [NRS-1:0][NRS-1:0]  older,
  output logic [NRS-1:0][OPW-1:0]  s_op,
  output logic [NRS-1:0][TW-1:0]   s_dst,
  output logic [NRS-1:0][DW-1:0]   s_a,
  output logic [NRS-1:0][DW-1:0]   s_b
);

  logic [NRS-1:0]           busy_q, issued_q, rdy_a_q, rdy_b_q, kind_q;
  logic [NRS-1:0][DW-1:0]   val_a_q, val_b_q;
  logic [NRS-1:0][TW-1:0]   tag_a_q, tag_b_q, dst_q;
  logic [NRS-1:0][OPW-1:0]  op_q;
  logic [NRS-1:0][NRS-1:0]  older_q;

  logic [NRS-1:0] hit_a, hit_b, eff_ra, eff_rb, release_s, alloc_oh;
  logic           new_a_hit, new_b_hit, do_alloc;

  // Wakeup: a matching broadcast counts as ready in the same cycle.
  always_comb begin
    for (int i = 0; i < NRS; i++) begin
      hit_a[i]     = cdb_valid && !rdy_a_q[i] && (tag_a_q[i] == cdb_tag);
      hit_b[i]     = cdb_valid && !rdy_b_q[i] && (tag_b_q[i] == cdb_tag);
      eff_ra[i]    = rdy_a_q[i] || hit_a[i];
      eff_rb[i]    = rdy_b_q[i] || hit_b[i];
      s_a[i]       = rdy_a_q[i] ? val_a_q[i] : cdb_val;
      s_b[i]       = rdy_b_q[i] ? val_b_q[i] : cdb_val;
      release_s[i] = busy_q[i] && issued_q[i] && cdb_valid && (dst_q[i] == cdb_tag);
      cand[i]      = busy_q[i] && !issued_q[i] && eff_ra[i] && eff_rb[i];
    end
  end

  // Lowest free index takes the next issued instruction.
  always_comb begin
    alloc_oh = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!busy_q[i]) alloc_oh = NRS'(1) << i;
    end
    if (!do_alloc) alloc_oh = '0;
  end

  assign iss_ready = !(&busy_q);
  assign do_alloc  = iss_valid && iss_ready;
  assign new_a_hit = cdb_valid && (cdb_tag == iss_a_tag);
  assign new_b_hit = cdb_valid && (cdb_tag == iss_b_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= '0;
      issued_q <= '0;
      older_q  <= '0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (alloc_oh[i]) begin
          busy_q[i]   <= 1'b1;
          issued_q[i] <= 1'b0;
          // Every station still occupied next cycle is older than this one.
          older_q[i]  <= busy_q & ~release_s;
        end else begin
          if (release_s[i]) busy_q[i] <= 1'b0;
          if (taken[i])     issued_q[i] <= 1'b1;
        end
      end
      for (int i = 0; i < NRS; i++) begin
        if (alloc_oh[i]) begin
          for (int k = 0; k < NRS; k++) begin
            if (k != i) older_q[k][i] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NRS; i++) begin
      if (alloc_oh[i]) begin
        kind_q[i]  <= iss_kind;
        op_q[i]    <= iss_op;
        dst_q[i]   <= iss_dst;
        tag_a_q[i] <= iss_a_tag;
        tag_b_q[i] <= iss_b_tag;
        rdy_a_q[i] <= iss_a_rdy || new_a_hit;
        rdy_b_q[i] <= iss_b_rdy || new_b_hit;
        val_a_q[i] <= iss_a_rdy ? iss_a_val : cdb_val;
        val_b_q[i] <= iss_b_rdy ? iss_b_val : cdb_val;
      end else begin
        if (hit_a[i]) begin
          rdy_a_q[i] <= 1'b1;
          val_a_q[i] <= cdb_val;
        end
        if (hit_b[i]) begin
          rdy_b_q[i] <= 1'b1;
          val_b_q[i] <= cdb_val;
        end
      end
    end
  end

  assign skind = kind_q;
  assign older = older_q;
  assign s_op  = op_q;
  assign s_dst = dst_q;

  // R10: the picker only takes occupied, undispatched stations whose operands are present
  assert_grant_eligible_R10: assert property (@(posedge clk) disable iff (rst)
    (taken & ~(busy_q & ~issued_q & eff_ra & eff_rb)) == '0);

  // R2: an accepted issue occupies its station on the next cycle
  assert_alloc_occupies_R2: assert property (@(posedge clk) disable iff (rst)
    (|alloc_oh) |=> ((busy_q & $past(alloc_oh)) == $past(alloc_oh)));

endmodule

// File: rtl/rs_pick.sv
module rs_pick
  import rs_pool_pkg::*;
#(
  parameter int NRS   = 4,
  parameter int NUM_A = 1,
  parameter int NU    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRS-1:0]          cand,
  input  logic [NRS-1:0]          skind,
  input  logic [NRS-1:0][NRS-1:0] older,
  input  logic [NU-1:0]           unit_free,
  output logic [NU-1:0][NRS-1:0]  grant,
  output logic [NRS-1:0]          taken
);

  // Units are served in index order; each takes the oldest eligible
  // station not already claimed by a lower-numbered unit.
  always_comb begin
    logic [NRS-1:0] avail;
    logic [NRS-1:0] mask;
    avail = cand;
    taken = '0;
    for (int u = 0; u < NU; u++) begin
      if (kind_of_unit(u, NUM_A) == KIND_B) mask = avail & skind;
      else                                  mask = avail & ~skind;
      if (!unit_free[u]) mask = '0;
      for (int i = 0; i < NRS; i++) begin
        grant[u][i] = mask[i] && ((older[i] & mask) == '0);
      end
      avail = avail & ~grant[u];
      taken = taken | grant[u];
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_chk
    // R5: a unit is given at most one station per cycle
    assert_one_per_unit_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[u]));
  end

endmodule

// File: rtl/rs_unit.sv
module rs_unit #(
  parameter int DW  = 32,
  parameter int TW  = 4,
  parameter int OPW = 4,
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [TW-1:0]  st_tag,
  input  logic [OPW-1:0] st_op,
  input  logic [DW-1:0]  st_a,
  input  logic [DW-1:0]  st_b,
  input  logic           cdb_valid,
  input  logic [TW-1:0]  cdb_tag,
  output logic           busy,
  output logic           done,
  output logic [TW-1:0]  tag,
  output logic [OPW-1:0] op,
  output logic [DW-1:0]  a,
  output logic [DW-1:0]  b
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (cdb_valid && (cdb_tag == tag)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      tag <= st_tag;
      op  <= st_op;
      a   <= st_a;
      b   <= st_b;
    end
  end

  // R7: a unit is only started while idle
  assert_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

  // R7: an occupied unit is not released before its latency has elapsed
  assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> busy_q);

  // R6: first execution cycle shows done only for a single-cycle unit
  assert_first_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && (done == (LAT == 1))));

endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int NUM_RS = 4,
  parameter int NUM_A  = 1,
  parameter int NUM_B  = 1,
  parameter int LAT_A  = 2,
  parameter int LAT_B  = 4,
  parameter int DW     = 32,
  parameter int TW     = 4,
  parameter int OPW    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           iss_valid,
  output logic                           iss_ready,
  input  logic                           iss_kind,
  input  logic [OPW-1:0]                 iss_op,
  input  logic [TW-1:0]                  iss_dst,
  input  logic                           iss_a_rdy,
  input  logic [TW-1:0]                  iss_a_tag,
  input  logic [DW-1:0]                  iss_a_val,
  input  logic                           iss_b_rdy,
  input  logic [TW-1:0]                  iss_b_tag,
  input  logic [DW-1:0]                  iss_b_val,
  input  logic                           cdb_valid,
  input  logic [TW-1:0]                  cdb_tag,
  input  logic [DW-1:0]                  cdb_val,
  output logic [NUM_A+NUM_B-1:0]         ex_busy,
  output logic [NUM_A+NUM_B-1:0]         ex_done,
  output logic [(NUM_A+NUM_B)*TW-1:0]    ex_tag,
  output logic [(NUM_A+NUM_B)*OPW-1:0]   ex_op,
  output logic [(NUM_A+NUM_B)*DW-1:0]    ex_a,
  output logic [(NUM_A+NUM_B)*DW-1:0]    ex_b
);

  localparam int NU = NUM_A + NUM_B;

  logic [NUM_RS-1:0]             cand, skind, taken;
  logic [NUM_RS-1:0][NUM_RS-1:0] older;
  logic [NUM_RS-1:0][OPW-1:0]    s_op;
  logic [NUM_RS-1:0][TW-1:0]     s_dst;
  logic [NUM_RS-1:0][DW-1:0]     s_a, s_b;
  logic [NU-1:0][NUM_RS-1:0]     grant;

  logic [NU-1:0]          u_start;
  logic [NU-1:0][TW-1:0]  u_tag;
  logic [NU-1:0][OPW-1:0] u_op;
  logic [NU-1:0][DW-1:0]  u_a, u_b;

  rs_slots #(.NRS(NUM_RS), .DW(DW), .TW(TW), .OPW(OPW)) slots (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_kind(iss_kind),
    .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .taken(taken), .cand(cand), .skind(skind), .older(older),
    .s_op(s_op), .s_dst(s_dst), .s_a(s_a), .s_b(s_b)
  );

  rs_pick #(.NRS(NUM_RS), .NUM_A(NUM_A), .NU(NU)) pick (
    .clk(clk), .rst(rst),
    .cand(cand), .skind(skind), .older(older),
    .unit_free(~ex_busy), .grant(grant), .taken(taken)
  );

  // Route the granted station's fields to its unit.
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      u_start[u] = |grant[u];
      u_tag[u]   = '0;
      u_op[u]    = '0;
      u_a[u]     = '0;
      u_b[u]     = '0;
      for (int i = 0; i < NUM_RS; i++) begin
        if (grant[u][i]) begin
          u_tag[u] = s_dst[i];
          u_op[u]  = s_op[i];
          u_a[u]   = s_a[i];
          u_b[u]   = s_b[i];
        end
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int L = (kind_of_unit(u, NUM_A) == KIND_A) ? LAT_A : LAT_B;
    rs_unit #(.DW(DW), .TW(TW), .OPW(OPW), .LAT(L)) unit (
      .clk(clk), .rst(rst),
      .start(u_start[u]), .st_tag(u_tag[u]), .st_op(u_op[u]),
      .st_a(u_a[u]), .st_b(u_b[u]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
      .busy(ex_busy[u]), .done(ex_done[u]),
      .tag(ex_tag[u*TW +: TW]), .op(ex_op[u*OPW +: OPW]),
      .a(ex_a[u*DW +: DW]), .b(ex_b[u*DW +: DW])
    );
  end

endmodule

// File: tb/rs_pool_test.sv
module rs_pool_test;

  localparam int CLK_PERIOD = 10;
  localparam int NRS = 4, NA = 1, NB = 1, LA = 2, LB = 3;
  localparam int DW = 16, TW = 4, OPW = 3;
  localparam int EW = TW + OPW + 2 * DW;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0, iss_kind = 1'b0, iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
  logic [OPW-1:0] iss_op = '0;
  logic [TW-1:0]  iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, cdb_tag = '0;
  logic [DW-1:0]  iss_a_val = '0, iss_b_val = '0, cdb_val = '0;
  logic           cdb_valid = 1'b0;
  logic           iss_ready;
  logic [1:0]     ex_busy, ex_done;
  logic [2*TW-1:0]  ex_tag;
  logic [2*OPW-1:0] ex_op;
  logic [2*DW-1:0]  ex_a, ex_b;

  int n_checks = 0, n_fail = 0;
  logic [EW-1:0] q0[$], q1[$];
  logic [1:0] prev_busy = '0;

  rs_pool #(.NUM_RS(NRS), .NUM_A(NA), .NUM_B(NB), .LAT_A(LA), .LAT_B(LB),
            .DW(DW), .TW(TW), .OPW(OPW)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_kind(iss_kind), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .ex_busy(ex_busy), .ex_done(ex_done), .ex_tag(ex_tag), .ex_op(ex_op),
    .ex_a(ex_a), .ex_b(ex_b)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic step();
    @(negedge clk);
    iss_valid = 1'b0;
    cdb_valid = 1'b0;
  endtask

  // Driver: present one issue; expected dispatch goes to the kind's queue.
  task automatic put_issue(input logic k, input logic [OPW-1:0] op, input logic [TW-1:0] dst,
                           input logic ar, input logic [TW-1:0] at, input logic [DW-1:0] av,
                           input logic [DW-1:0] bv, input logic [DW-1:0] a_exp,
                           input logic expect_it);
    iss_valid = 1'b1; iss_kind = k; iss_op = op; iss_dst = dst;
    iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
    iss_b_rdy = 1'b1; iss_b_tag = '0; iss_b_val = bv;
    if (expect_it) begin
      if (k) q1.push_back({dst, op, a_exp, bv});
      else   q0.push_back({dst, op, a_exp, bv});
    end
  endtask

  task automatic put_cdb(input logic [TW-1:0] t, input logic [DW-1:0] v);
    cdb_valid = 1'b1; cdb_tag = t; cdb_val = v;
  endtask

  // Wait for the unit's result, then broadcast it as write-result.
  task automatic finish_unit(input int u);
    int w = 0;
    while (!ex_done[u] && w < 30) begin step(); w++; end
    chk("R6 unit reaches done", 64'(ex_done[u]), 64'd1);
    put_cdb(ex_tag[u*TW +: TW], 16'hFFFF);
    step();
  endtask

  // Monitor: each unit start is compared with the next expected dispatch.
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < 2; u++) begin
        if (ex_busy[u] && !prev_busy[u]) begin
          logic [EW-1:0] got, exp;
          got = {ex_tag[u*TW +: TW], ex_op[u*OPW +: OPW], ex_a[u*DW +: DW], ex_b[u*DW +: DW]};
          if (u == 0 && q0.size() > 0)      exp = q0.pop_front();
          else if (u == 1 && q1.size() > 0) exp = q1.pop_front();
          else                              exp = 'x;
          chk("R5 dispatch order and operands", 64'(got), 64'(exp));
        end
      end
    end
    prev_busy = ex_busy;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 iss_ready", 64'(iss_ready), 64'd1);
    chk("R1 ex_busy", 64'(ex_busy), 64'd0);
    chk("R1 ex_done", 64'(ex_done), 64'd0);

    // R6/R7/R9: a ready kind-A instruction
    put_issue(1'b0, 3'd1, 4'd1, 1'b1, 4'd0, 16'h0010, 16'h0020, 16'h0010, 1'b1);
    step();
    chk("R6 not started in issue+1", 64'(ex_busy[0]), 64'd0);
    step();
    chk("R6 started", 64'(ex_busy[0]), 64'd1);
    chk("R6 done low at s", 64'(ex_done[0]), 64'd0);
    chk("R9 kind B unit idle", 64'(ex_busy[1]), 64'd0);
    step();
    chk("R6 done at s+LAT-1", 64'(ex_done[0]), 64'd1);
    step();
    chk("R7 held until write-result", 64'(ex_busy[0]), 64'd1);
    put_cdb(4'd1, 16'h1111);
    step();
    chk("R7 freed after write-result", 64'(ex_busy[0]), 64'd0);

    // R10/R3: waiting operand, woken by a broadcast
    put_issue(1'b0, 3'd2, 4'd2, 1'b0, 4'd9, 16'h0000, 16'h0022, 16'h0055, 1'b1);
    step(); step(); step();
    chk("R10 waiting station not dispatched", 64'(ex_busy[0]), 64'd0);
    put_cdb(4'd9, 16'h0055);
    step();
    chk("R3 start the cycle after broadcast", 64'(ex_busy[0]), 64'd1);
    chk("R3 broadcast value used", 64'(ex_a[DW-1:0]), 64'h55);
    finish_unit(0);

    // R4/R6/R9: broadcast in the allocation cycle, kind B
    put_issue(1'b1, 3'd3, 4'd3, 1'b0, 4'd7, 16'h0000, 16'h0033, 16'h0077, 1'b1);
    put_cdb(4'd7, 16'h0077);
    step();
    chk("R4 not started in issue+1", 64'(ex_busy[1]), 64'd0);
    step();
    chk("R4 started issue+2", 64'(ex_busy[1]), 64'd1);
    chk("R4 captured value", 64'(ex_a[2*DW-1:DW]), 64'h77);
    chk("R9 kind A unit idle", 64'(ex_busy[0]), 64'd0);
    step();
    chk("R6 kind B done low at s+1", 64'(ex_done[1]), 64'd0);
    step();
    chk("R6 kind B done at s+2", 64'(ex_done[1]), 64'd1);
    finish_unit(1);

    // R5: age order beats station index
    put_issue(1'b0, 3'd4, 4'd4, 1'b1, 4'd0, 16'h0004, 16'h0044, 16'h0004, 1'b1);
    step();
    put_issue(1'b0, 3'd5, 4'd5, 1'b0, 4'd10, 16'h0000, 16'h0045, 16'h00A0, 1'b1);
    step();
    put_issue(1'b0, 3'd6, 4'd6, 1'b0, 4'd11, 16'h0000, 16'h0046, 16'h00B0, 1'b1);
    step();
    put_cdb(4'd10, 16'h00A0);
    step();
    put_cdb(4'd11, 16'h00B0);
    step();
    chk("R7 other tags leave unit busy", 64'(ex_busy[0]), 64'd1);
    chk("R7 unit still holds tag 4", 64'(ex_tag[TW-1:0]), 64'd4);
    put_cdb(4'd4, 16'h0404);
    step();
    chk("R8 station free after write-result", 64'(iss_ready), 64'd1);
    put_issue(1'b0, 3'd7, 4'd8, 1'b1, 4'd0, 16'h0088, 16'h0089, 16'h0088, 1'b1);
    step();
    finish_unit(0);
    chk("R7 unit idle the cycle after write-result", 64'(ex_busy[0]), 64'd0);
    step();
    chk("R7 restart two cycles after write-result", 64'(ex_busy[0]), 64'd1);
    chk("R5 older station 6 before younger 8", 64'(ex_tag[TW-1:0]), 64'd6);
    finish_unit(0);
    finish_unit(0);

    // R2/R8: fill the pool, reject, drain
    put_issue(1'b1, 3'd1, 4'd9,  1'b0, 4'd14, 16'h0, 16'h0009, 16'h00EE, 1'b1); step();
    put_issue(1'b1, 3'd2, 4'd10, 1'b0, 4'd14, 16'h0, 16'h000A, 16'h00EE, 1'b1); step();
    put_issue(1'b1, 3'd3, 4'd11, 1'b0, 4'd14, 16'h0, 16'h000B, 16'h00EE, 1'b1); step();
    put_issue(1'b1, 3'd4, 4'd12, 1'b0, 4'd14, 16'h0, 16'h000C, 16'h00EE, 1'b1); step();
    chk("R2 full pool not ready", 64'(iss_ready), 64'd0);
    put_issue(1'b1, 3'd5, 4'd13, 1'b1, 4'd0, 16'h00DD, 16'h000D, 16'h00DD, 1'b0);
    step();
    put_cdb(4'd14, 16'h00EE);
    step();
    finish_unit(1);
    chk("R8 ready again after first write-result", 64'(iss_ready), 64'd1);
    finish_unit(1);
    finish_unit(1);
    finish_unit(1);
    repeat (8) step();
    chk("R2 rejected issue never dispatched", 64'(ex_busy), 64'd0);
    chk("R2 all expected dispatches seen", 64'(q0.size() + q1.size()), 64'd0);

    summary();
    $finish;
  end

endmodule